// File: doc/BRIEF.md
# Downstream Bus Mode Probe

This block works out, after every reset release, which operating mode and clock range a bridge's downstream bus can run at. It looks at one shared capability line that every attached device either pulls low through its own load, ties to ground, or leaves alone. The line is first read with the block's strong pull-up control switched off. A high reading means every device can run the fastest protocol. The block then reads a frequency-select input to choose between the upper and the lower clock band. A low reading has two possible causes. To tell them apart, the block switches on the strong pull-up control, waits a settle interval, and reads the line again.

The result is a registered 2-bit mode code and a done flag. When the result is conventional PCI, the block asserts a PLL bypass output, so the incoming bus clock is used directly. For any PCI-X result, the done flag is held back until the PLL has had time to lock. That happens when the lock input is seen, or when a lock window counted from reset release has run out, whichever comes first. Both sampled inputs pass through a two-flop synchronizer. All timing below is counted in rising clock edges after reset release: edge 1 is the first rising edge with reset high.

Top module: `bus_mode_probe`

## Requirements
- R1: While reset is low, `pu_en_o`, `pll_bypass_o`, `done_o` and `mode_o` are all 0. Each reset release starts a new detection from the beginning, even if the previous one had not finished.
- R2: The first read of the capability line happens with the pull-up control off. If that read is low, `pu_en_o` goes high at edge 3. Otherwise it stays low.
- R3: After the pull-up is on, the line is read again once SETTLE_CYCLES edges have passed. If it is still low, `mode_o` becomes 00 (conventional PCI) and `done_o` rises at edge SETTLE_CYCLES+4.
- R4: If the second read is high, `mode_o` becomes 01 (PCI-X 66).
- R5: If the first read is high, the frequency-select input decides the mode: high gives 10 (PCI-X 100) and low gives 11 (PCI-X 133). In this case `pu_en_o` stays low.
- R6: For a PCI-X result, `done_o` rises one edge after the decision if `pll_lock_i` is high. Otherwise it rises at edge LOCK_CYCLES+1, but never earlier than one edge after the decision. The decision edge is 4 on the high branch and SETTLE_CYCLES+4 on the low branch.
- R7: Once `done_o` is high, it and `mode_o` hold until the next reset, whatever the inputs do.
- R8: `pll_bypass_o` is high exactly when `done_o` is high and the mode is 00.
- R9: `pu_en_o` never falls once it has risen, until reset.
- R10: On the low branch, the frequency-select input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts detection |
| cap_i | input | 1 | Shared capability line (asynchronous) |
| fsel_i | input | 1 | Frequency-band select (asynchronous); high selects the lower PCI-X band |
| pll_lock_i | input | 1 | PLL lock indication, synchronous to clk |
| pu_en_o | output | 1 | Strong pull-up enable for the capability line |
| pll_bypass_o | output | 1 | Use the bus clock directly, PLL bypassed |
| mode_o | output | 2 | 00 conventional, 01 PCI-X 66, 10 PCI-X 100, 11 PCI-X 133 |
| done_o | output | 1 | Detection finished and mode valid |

## Verification
The in-line assertions check, on every cycle, these properties:
- the pull-up enable never falls once it has risen;
- it only rises after a low first reading;
- the done flag and the mode hold once done is set;
- bypass appears only with a finished conventional result;
- a PCI-X completion only follows a lock indication or an expired lock window;
- the lock window, once expired, stays expired.

Some points can only be shown by the bench scenarios, which compare against a behavioural model on every clock:
- the edge on which done rises for each of the four outcomes, with and without early lock;
- the exact mode code chosen;
- that the frequency select is ignored on the low branch;
- that a reset in the middle of a detection restarts it cleanly.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_X66  = 2'b01,
        MODE_X100 = 2'b10,
        MODE_X133 = 2'b11
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_PROBE1,
        ST_SETTLE,
        ST_PROBE2,
        ST_FSEL,
        ST_LOCK,
        ST_DONE
    } probe_state_e;

endpackage

// File: rtl/bmp_sync.sv
module bmp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/bmp_lock_timer.sv
module bmp_lock_timer #(
    parameter int LOCK_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic elapsed_o
);
    localparam int TW = $clog2(LOCK_CYCLES + 1);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != TW'(LOCK_CYCLES)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign elapsed_o = (cnt_q == TW'(LOCK_CYCLES));

    // R6
    elapsed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_o |=> elapsed_o);
endmodule

// File: rtl/bmp_fsm.sv
module bmp_fsm
    import bmp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int FILL_CYCLES   = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_s_i,
    input  logic      fsel_s_i,
    input  logic      lock_ok_i,
    output logic      pu_en_o,
    output logic      bypass_o,
    output bus_mode_e mode_o,
    output logic      done_o
);
    localparam int CMAX = (SETTLE_CYCLES > FILL_CYCLES) ? SETTLE_CYCLES : FILL_CYCLES;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        probe_state_e  state;
        logic [CW-1:0] cnt;
        bus_mode_e     mode;
        logic          pu_en;
        logic          bypass;
        logic          done;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_FILL: begin
                if (st_q.cnt == CW'(FILL_CYCLES - 1)) begin
                    st_d.state = ST_PROBE1;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_PROBE1: begin
                if (cap_s_i) begin
                    st_d.state = ST_FSEL;
                end else begin
                    st_d.pu_en = 1'b1;
                    st_d.cnt   = '0;
                    st_d.state = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (st_q.cnt == CW'(SETTLE_CYCLES - 1)) st_d.state = ST_PROBE2;
                else                                    st_d.cnt   = st_q.cnt + 1'b1;
            end
            ST_PROBE2: begin
                if (cap_s_i) begin
                    st_d.mode  = MODE_X66;
                    st_d.state = ST_LOCK;
                end else begin
                    st_d.mode   = MODE_CONV;
                    st_d.bypass = 1'b1;
                    st_d.done   = 1'b1;
                    st_d.state  = ST_DONE;
                end
            end
            ST_FSEL: begin
                st_d.mode  = fsel_s_i ? MODE_X100 : MODE_X133;
                st_d.state = ST_LOCK;
            end
            ST_LOCK: begin
                if (lock_ok_i) begin
                    st_d.done  = 1'b1;
                    st_d.state = ST_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_FILL, cnt: '0, mode: MODE_CONV,
                      pu_en: 1'b0, bypass: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pu_en_o  = st_q.pu_en;
    assign bypass_o = st_q.bypass;
    assign mode_o   = st_q.mode;
    assign done_o   = st_q.done;

    // R9
    pu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_en_o |=> pu_en_o);
    // R2
    pu_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_en_o) |-> !$past(cap_s_i));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o && $stable(mode_o));
    // R8
    bypass_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_o |-> done_o && mode_o == MODE_CONV);
    // R6
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && mode_o != MODE_CONV) |-> $past(lock_ok_i));
endmodule

// File: rtl/bus_mode_probe.sv
module bus_mode_probe
    import bmp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int LOCK_CYCLES   = 12500,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  logic       fsel_i,
    input  logic       pll_lock_i,
    output logic       pu_en_o,
    output logic       pll_bypass_o,
    output logic [1:0] mode_o,
    output logic       done_o
);
    logic [1:0] raw_in;
    logic [1:0] syn_in;
    logic       elapsed;
    logic       lock_ok;
    bus_mode_e  mode;

    assign raw_in = {fsel_i, cap_i};

    bmp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    bmp_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .elapsed_o (elapsed)
    );

    assign lock_ok = elapsed | pll_lock_i;

    bmp_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES), .FILL_CYCLES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_s_i   (syn_in[0]),
        .fsel_s_i  (syn_in[1]),
        .lock_ok_i (lock_ok),
        .pu_en_o   (pu_en_o),
        .bypass_o  (pll_bypass_o),
        .mode_o    (mode),
        .done_o    (done_o)
    );

    assign mode_o = mode;
endmodule

// File: tb/bus_mode_probe_tb.sv
module bus_mode_probe_tb;
    localparam int S    = 16;
    localparam int LOCK = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_tie = 1'b0;
    logic cap_lvl = 1'b0;
    logic fsel = 1'b0;
    logic lock_in = 1'b0;
    logic cap;
    logic pu_en, bypass, done;
    logic [1:0] mode;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    // Bus model: a tied device forces low; otherwise the strong pull-up wins.
    assign cap = cap_tie ? 1'b0 : (pu_en ? 1'b1 : cap_lvl);

    bus_mode_probe #(.SETTLE_CYCLES(S), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .fsel_i(fsel),
        .pll_lock_i(lock_in), .pu_en_o(pu_en), .pll_bypass_o(bypass),
        .mode_o(mode), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // stop_at < 0 runs to completion plus a tail; otherwise abort (restart case)
    task automatic run(input logic tie, input logic hi, input logic fs,
                       input logic lk, input int stop_at);
        logic conv, x66;
        int   dec, done_e, n, mode_e, last;
        @(negedge clk);
        rst_n = 1'b0;
        cap_tie = tie; cap_lvl = hi; fsel = fs; lock_in = lk;
        repeat (3) @(negedge clk);
        chk("R1 reset pu_en", int'(pu_en), 0);
        chk("R1 reset bypass", int'(bypass), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset mode", int'(mode), 0);
        rst_n = 1'b1;
        conv = !hi && tie;
        x66  = !hi && !tie;
        dec  = hi ? 4 : S + 4;
        if (conv) done_e = S + 4;
        else begin
            done_e = dec + 1;
            if (!lk && LOCK + 1 > done_e) done_e = LOCK + 1;
        end
        mode_e = conv ? 0 : x66 ? 1 : (fs ? 2 : 3);
        last = (stop_at >= 0) ? stop_at : done_e + 30;
        for (n = 1; n <= last; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2/R9 pu_en", int'(pu_en), int'(!hi && n >= 3));
            chk("R3/R6 done", int'(done), int'(n >= done_e));
            chk("R8 bypass", int'(bypass), int'(conv && n >= done_e));
            if (n >= done_e) begin
                if (conv)      chk("R3 mode conv", int'(mode), mode_e);
                else if (x66)  chk("R4 mode x66", int'(mode), mode_e);
                else           chk("R5 mode hi branch", int'(mode), mode_e);
            end
            // R7: inputs changed after completion must not disturb the result
            if (n == done_e + 5) begin
                fsel = ~fsel; cap_tie = ~cap_tie; cap_lvl = ~cap_lvl; lock_in = ~lock_in;
            end
            // R10: frequency select toggled during the low branch probe
            if (!hi && n == 6) fsel = ~fsel;
        end
    endtask

    initial begin
        // R1 restart: abort a detection halfway through settling
        run(1'b0, 1'b0, 1'b0, 1'b0, 10);
        run(1'b1, 1'b0, 1'b1, 1'b0, -1); // R3 conventional, R10 fsel ignored
        run(1'b0, 1'b0, 1'b0, 1'b0, -1); // R4 x66, lock window
        run(1'b0, 1'b0, 1'b1, 1'b1, -1); // R4 x66, early lock
        run(1'b0, 1'b1, 1'b1, 1'b0, -1); // R5 x100, lock window
        run(1'b0, 1'b1, 1'b0, 1'b1, -1); // R5 x133, early lock
        run(1'b0, 1'b1, 1'b0, 1'b0, -1); // R5 x133, lock window
        run(1'b1, 1'b0, 1'b0, 1'b1, -1); // R3 conventional, lock input irrelevant
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule